// File: doc/BRIEF.md
# Supply Monitor Reset Controller

This block is the digital half of a supply-voltage supervisor that can act as a system reset source. An analog comparator elsewhere reports whether the supply sits above its threshold. The block synchronizes that level, holds a small control/status register, and times how long the monitor takes to settle after it is switched on. It drives the system reset whenever the monitor is enabled, selected as a reset source and sees a low supply.

Reset stays asserted while the supply is low. After the supply recovers, reset is held for a programmable number of extra cycles. A power-fail flag tells software that memory contents may have been lost. The enable bit survives every reset except power-on. Until the settle time has elapsed, the monitor output is forced to "supply low". Selecting the monitor as a source too early therefore produces a reset, much as a real unsettled comparator would.

Top module: `supmon_rst_ctrl`

## Requirements
- R1: Register layout: bit 7 is the monitor enable (read/write), bit 6 is the supply status (read-only, writes ignored), and bits 5..0 read 0 and ignore writes.
- R2: The status bit reads 1 when the comparator reports the supply above threshold and 0 when it is at or below threshold. It follows the comparator through a two-flop synchronizer and is valid within 4 cycles.
- R3: With the monitor enabled, settled and selected (`src_sel_i`=1), a low supply asserts `sys_rst_o` within 4 cycles and holds it for as long as the supply stays low.
- R4: With the monitor disabled or not selected, a low supply never asserts `sys_rst_o`.
- R5: After the supply recovers, `sys_rst_o` stays asserted for REL_CYCLES further cycles. It is still 1 REL_CYCLES cycles after the comparator rises and is 0 by REL_CYCLES+4 cycles.
- R6: Only `rst_ni` (power-on) clears the enable bit. A pulse on `ext_rst_req_i` asserts `sys_rst_o` for at least one cycle and leaves the enable bit unchanged.
- R7: `pwr_fail_o` is 1 after power-on and after any monitor-triggered reset, including through the release delay. `pf_clr_i` clears it only while no monitor trip is active. An `ext_rst_req_i` pulse also clears it.
- R8: For STAB_CYCLES cycles after the enable goes from 0 to 1, the monitor output is forced low. A selected monitor then asserts `sys_rst_o` even with the supply high. Once it has settled, a high supply causes no reset.
- R9: Clearing the enable stops monitor resets. Setting it again restarts the settle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| cmp_above_i | input | 1 | Asynchronous comparator level, 1 = supply above threshold |
| src_sel_i | input | 1 | Monitor selected as a reset source |
| ext_rst_req_i | input | 1 | Reset request from another source |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register read data |
| pf_clr_i | input | 1 | Software clear of the power-fail flag |
| sys_rst_o | output | 1 | System reset request, active high |
| pwr_fail_o | output | 1 | Power-fail flag |

## Verification
The bench goes after the early-selection hazard. A design that treats the monitor as settled at once would miss the spurious reset after enable, and a design that never settles would keep the system in reset indefinitely. It times the release window from the comparator edge, which catches a missing or shortened delay. It also tries to clear the flag while a trip is active, where a wrong priority would lose the power-fail indication. Finally, it applies external resets and a power-on reset to confirm that only power-on drops the enable bit.

// File: rtl/supmon_pkg.sv
package supmon_pkg;
  localparam int REG_W    = 8;
  localparam int EN_BIT   = 7;
  localparam int STAT_BIT = 6;
endpackage

// File: rtl/supmon_sync.sv
module supmon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/supmon_stab.sv
module supmon_stab #(
  parameter int STAB_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic stable_o
);
  localparam int CW = $clog2(STAB_CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(STAB_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!en_i)       cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign stable_o = (cnt_q == LIM);

  a_r8_off_unstable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !stable_o);
  a_r9_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |-> !stable_o);
endmodule

// File: rtl/supmon_rst_gen.sv
module supmon_rst_gen #(
  parameter int REL_CYCLES = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trip_i,
  input  logic ext_req_i,
  input  logic pf_clr_i,
  output logic sys_rst_o,
  output logic pwr_fail_o
);
  localparam int RW = $clog2(REL_CYCLES + 1);
  localparam logic [RW-1:0] REL = RW'(REL_CYCLES);

  logic [RW-1:0] rel_q;
  logic          rst_q;
  logic          pf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rel_q <= '0;
      rst_q <= 1'b1;
    end else begin
      if (trip_i)            rel_q <= REL;
      else if (rel_q != '0)  rel_q <= rel_q - 1'b1;
      rst_q <= trip_i | ext_req_i | (rel_q != '0);
    end
  end

  // trip sets, other reset sources overwrite, software clears last
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pf_q <= 1'b1;
    else if (trip_i)    pf_q <= 1'b1;
    else if (ext_req_i) pf_q <= 1'b0;
    else if (pf_clr_i)  pf_q <= 1'b0;
  end

  assign sys_rst_o  = rst_q;
  assign pwr_fail_o = pf_q;

  a_r3_trip_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_i |=> sys_rst_o);
  a_r7_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_i |=> pwr_fail_o);
  a_r5_no_release_in_trip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> !$past(trip_i));
  a_r6_ext_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_req_i |=> sys_rst_o);
endmodule

// File: rtl/supmon_rst_ctrl.sv
module supmon_rst_ctrl
  import supmon_pkg::*;
#(
  parameter int STAB_CYCLES = 16,
  parameter int REL_CYCLES  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_above_i,
  input  logic             src_sel_i,
  input  logic             ext_rst_req_i,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             pf_clr_i,
  output logic             sys_rst_o,
  output logic             pwr_fail_o
);
  logic cmp_s;
  logic en_q;
  logic stable;
  logic mon_ok;
  logic trip;

  supmon_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_above_i),
    .q_o   (cmp_s)
  );

  // enable: cleared by power-on only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_q <= 1'b0;
    else if (reg_we_i) en_q <= reg_wdata_i[EN_BIT];
  end

  supmon_stab #(.STAB_CYCLES(STAB_CYCLES)) u_stab (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_q),
    .stable_o(stable)
  );

  // unsettled monitor reads as supply low
  assign mon_ok = stable & cmp_s;
  assign trip   = en_q & src_sel_i & ~mon_ok;

  supmon_rst_gen #(.REL_CYCLES(REL_CYCLES)) u_rst_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trip_i    (trip),
    .ext_req_i (ext_rst_req_i),
    .pf_clr_i  (pf_clr_i),
    .sys_rst_o (sys_rst_o),
    .pwr_fail_o(pwr_fail_o)
  );

  always_comb begin
    reg_rdata_o           = '0;
    reg_rdata_o[EN_BIT]   = en_q;
    reg_rdata_o[STAT_BIT] = cmp_s;
  end

  a_r6_en_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_we_i |=> $stable(en_q));
  a_r4_idle_no_trip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!src_sel_i || !en_q) |-> !trip);
endmodule

// File: tb/supmon_rst_ctrl_tb.sv
`timescale 1ns/1ps
module supmon_rst_ctrl_tb_top;
  localparam int STAB = 16;
  localparam int REL  = 12;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmp_above_i = 1'b1;
  logic       src_sel_i = 1'b0;
  logic       ext_rst_req_i = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       pf_clr_i = 1'b0;
  logic       sys_rst_o;
  logic       pwr_fail_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  supmon_rst_ctrl #(.STAB_CYCLES(STAB), .REL_CYCLES(REL)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmp_above_i(cmp_above_i),
    .src_sel_i(src_sel_i), .ext_rst_req_i(ext_rst_req_i),
    .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .pf_clr_i(pf_clr_i), .sys_rst_o(sys_rst_o), .pwr_fail_o(pwr_fail_o)
  );

  always #5 clk_i = ~clk_i;

  // {cmp, we, wdata[7:0], exp_rdata[7:0]}, monitor not selected
  localparam logic [17:0] VEC [0:5] = '{
    {1'b1, 1'b1, 8'h3F, 8'h40},
    {1'b1, 1'b1, 8'hFF, 8'hC0},
    {1'b0, 1'b0, 8'h00, 8'h80},
    {1'b0, 1'b1, 8'h7F, 8'h00},
    {1'b1, 1'b1, 8'h80, 8'hC0},
    {1'b1, 1'b1, 8'h40, 8'h40}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    reg_we_i = 1'b1; reg_wdata_i = d;
    tick(1);
    reg_we_i = 1'b0;
  endtask

  task automatic clr_pf();
    pf_clr_i = 1'b1; tick(1); pf_clr_i = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=1 exp=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(2);
    rst_ni = 1'b1;
    tick(4);
    // reset state
    chk("R1 reset rdata", reg_rdata_o, 8'h40);
    chk("R7 reset flag", {7'b0, pwr_fail_o}, 8'h01);
    chk("R6 reset released", {7'b0, sys_rst_o}, 8'h00);
    clr_pf();
    chk("R7 sw clear", {7'b0, pwr_fail_o}, 8'h00);

    for (int i = 0; i < 6; i++) begin
      cmp_above_i = VEC[i][17];
      if (VEC[i][16]) wr(VEC[i][15:8]);
      tick(4);
      chk($sformatf("R1 R2 vec%0d rdata", i), reg_rdata_o, VEC[i][7:0]);
      chk($sformatf("R4 vec%0d no reset", i), {7'b0, sys_rst_o}, 8'h00);
    end

    // early selection: spurious reset
    cmp_above_i = 1'b1;
    src_sel_i = 1'b1;
    wr(8'h80);
    tick(2);
    chk("R8 early select resets", {7'b0, sys_rst_o}, 8'h01);
    tick(STAB + REL + 8);
    chk("R8 settled releases", {7'b0, sys_rst_o}, 8'h00);
    clr_pf();
    chk("R7 clear after settle", {7'b0, pwr_fail_o}, 8'h00);

    // supply drop
    cmp_above_i = 1'b0;
    tick(4);
    chk("R3 low asserts", {7'b0, sys_rst_o}, 8'h01);
    tick(20);
    chk("R3 held while low", {7'b0, sys_rst_o}, 8'h01);
    clr_pf();
    chk("R7 clear ignored in trip", {7'b0, pwr_fail_o}, 8'h01);

    // recovery and delay
    cmp_above_i = 1'b1;
    tick(REL);
    chk("R5 still held", {7'b0, sys_rst_o}, 8'h01);
    chk("R7 flag through delay", {7'b0, pwr_fail_o}, 8'h01);
    tick(4);
    chk("R5 released", {7'b0, sys_rst_o}, 8'h00);

    // other reset source overwrites flag, keeps enable
    ext_rst_req_i = 1'b1; tick(1); ext_rst_req_i = 1'b0;
    chk("R6 ext asserts reset", {7'b0, sys_rst_o}, 8'h01);
    chk("R7 ext clears flag", {7'b0, pwr_fail_o}, 8'h00);
    tick(3);
    chk("R6 enable kept", reg_rdata_o, 8'hC0);

    // not selected
    src_sel_i = 1'b0;
    cmp_above_i = 1'b0;
    tick(6);
    chk("R4 unselected no reset", {7'b0, sys_rst_o}, 8'h00);
    chk("R4 unselected no flag", {7'b0, pwr_fail_o}, 8'h00);

    // disabled
    wr(8'h00);
    src_sel_i = 1'b1;
    tick(6);
    chk("R9 disabled no reset", {7'b0, sys_rst_o}, 8'h00);
    cmp_above_i = 1'b1;
    tick(4);
    wr(8'h80);
    tick(2);
    chk("R9 re-enable restarts settle", {7'b0, sys_rst_o}, 8'h01);
    tick(STAB + REL + 8);
    chk("R9 settles again", {7'b0, sys_rst_o}, 8'h00);

    // power-on clears enable
    rst_ni = 1'b0; tick(1); rst_ni = 1'b1;
    src_sel_i = 1'b0;
    tick(4);
    chk("R6 power-on clears enable", reg_rdata_o, 8'h40);
    chk("R7 power-on sets flag", {7'b0, pwr_fail_o}, 8'h01);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule